// File: doc/BRIEF.md
# Serial Wire Debug Transaction Monitor

This block listens passively to the two wires of a Serial Wire Debug link: the debug clock and the bidirectional data line. Both wires are sampled in the system clock domain. The block rebuilds every transaction from the wires: the 8-bit request, the 3-bit acknowledge and, when one is present, the 32-bit data word with its parity bit. It follows the wire's direction changes. Requests and host-driven write data are taken on rising debug-clock edges. Acknowledges and target-driven read data are taken on falling edges, and the turnaround edges between them are skipped.

Two control bits written over the link are kept in a small shadow: a select bit and an overrun-detect bit. When overrun detection is on, a WAIT or FAULT reply is still followed by a data phase, so the monitor needs the shadowed value to stay aligned with the bit stream. Each finished transaction produces one record, marked by a single-cycle strobe. The record can feed a trace buffer or a protocol checker.

Top module: `swd_txn_monitor`

## Requirements
- R1: After reset `rec_valid` is 0 and every record field is 0.
- R2: While waiting for a request, the monitor takes one bit per rising debug-clock edge. It starts a transaction when the last eight bits, oldest first, are: 1, AP-select, read, A2, A3, parity, 0, 1. `rec_ap` is the AP-select bit, `rec_read` is the read bit, and `rec_addr` = {A3, A2, 2'b00}.
- R3: The request parity bit must give even parity together with AP-select, read, A2 and A3. On a mismatch `rec_req_perr` is 1 and the transaction is still decoded.
- R4: After the request the next falling edge is skipped, and three bits are then taken on falling edges. `rec_ack` holds them first-arrived in bit 2: 3'b100 is OK, 3'b010 is WAIT, 3'b001 is FAULT and 3'b111 is no reply. Any other value is a protocol error.
- R5: On a read that has a data phase, 32 bits follow the acknowledge at once on falling edges, least significant bit first, and then one parity bit. `rec_data_perr` is 1 when the 33 bits have odd parity.
- R6: On a write that has a data phase, two rising edges after the acknowledge are skipped. The 32 data bits and the parity bit are then taken on rising edges.
- R7: After a read with a data phase, one rising edge is skipped before the next request bit. After a write with a data phase, none is skipped.
- R8: Without a data phase, the record carries `rec_data` = 0 and `rec_data_perr` = 0. After WAIT or FAULT, one rising edge is skipped before the next request. After no reply or an error, none is skipped.
- R9: An OK reply always has a data phase. WAIT and FAULT have one only while the overrun-detect shadow bit is 1.
- R10: A DP write (AP-select 0) that gets OK and correct data parity works on the shadow bits as follows. At address 0x8 it loads data bit 0 into the select shadow bit. At address 0x4, and only while the select shadow bit is 0, it loads data bit 0 into the overrun-detect shadow bit. Both shadow bits are 0 after reset.
- R11: `rec_valid` is high for exactly one system-clock cycle per transaction. The record fields keep their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the debug clock |
| rst_n | input | 1 | Active-low reset |
| swclk_i | input | 1 | Observed debug clock wire |
| swdio_i | input | 1 | Observed debug data wire |
| rec_valid | output | 1 | One-cycle strobe for a finished transaction |
| rec_ap | output | 1 | 1 = access port, 0 = debug port |
| rec_read | output | 1 | 1 = read, 0 = write |
| rec_addr | output | 4 | Register byte address |
| rec_ack | output | 3 | Acknowledge bits, first-arrived in bit 2 |
| rec_data | output | DW | Data word, 0 when there was no data phase |
| rec_req_perr | output | 1 | Request parity mismatch |
| rec_data_perr | output | 1 | Data parity mismatch |

## Verification
The bound checker checks on every cycle that the strobe lasts one cycle and that the record fields stay frozen between strobes. It also checks that a no-reply record never carries data, and that a data parity error is only reported for a reply that has a data phase.

Edge selection, turnaround skipping, LSB-first assembly and the shadow-driven choice between a data phase and an early return can only be seen through bit streams. The scoreboard bench supplies these streams: back-to-back transactions with no idle cycles, injected parity faults, and a sequence of control writes that turns overrun detection on, tries to turn it off while the select bit blocks the write, and then turns it off.

// File: rtl/swd_txn_monitor.sv
module swd_txn_monitor #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swclk_i,
  input  logic          swdio_i,
  output logic          rec_valid,
  output logic          rec_ap,
  output logic          rec_read,
  output logic [3:0]    rec_addr,
  output logic [2:0]    rec_ack,
  output logic [DW-1:0] rec_data,
  output logic          rec_req_perr,
  output logic          rec_data_perr
);
  localparam int CW = $clog2(DW);
  localparam logic [2:0] ACK_OK = 3'b100, ACK_WAIT = 3'b010, ACK_FAULT = 3'b001;

  typedef enum logic [1:0] {S_REQ, S_ACK, S_DATA, S_DPAR} st_t;

  logic [1:0]    ck_s, io_s;
  logic          ck_d;
  st_t           st;
  logic          on_fall;
  logic [1:0]    skip;
  logic [7:0]    rq;
  logic [2:0]    ak;
  logic [DW-1:0] dsh;
  logic [CW-1:0] cnt;
  logic          cur_ap, cur_rd, cur_rp;
  logic [1:0]    cur_a;
  logic          csel, orun;

  wire           rise     = ck_s[1] & ~ck_d;
  wire           fall     = ~ck_s[1] & ck_d;
  wire           bit_i    = io_s[1];
  wire           take     = on_fall ? fall : rise;
  wire [7:0]     rq_n     = {rq[6:0], bit_i};
  wire [2:0]     ak_n     = {ak[1:0], bit_i};
  wire           req_hit  = rq_n[7] & ~rq_n[1] & rq_n[0];
  wire           wf       = (ak_n == ACK_WAIT) || (ak_n == ACK_FAULT);
  wire           data_ack = (ak_n == ACK_OK) || (wf && orun);
  wire           dp_bad   = bit_i ^ (^dsh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      io_s <= '0;
      ck_d <= 1'b0;
    end else begin
      ck_s <= {ck_s[0], swclk_i};
      io_s <= {io_s[0], swdio_i};
      ck_d <= ck_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_REQ;
      on_fall <= 1'b0;
      skip <= '0;
      rq <= '0;
      ak <= '0;
      dsh <= '0;
      cnt <= '0;
      cur_ap <= 1'b0;
      cur_rd <= 1'b0;
      cur_rp <= 1'b0;
      cur_a <= '0;
      csel <= 1'b0;
      orun <= 1'b0;
      rec_valid <= 1'b0;
      rec_ap <= 1'b0;
      rec_read <= 1'b0;
      rec_addr <= '0;
      rec_ack <= '0;
      rec_data <= '0;
      rec_req_perr <= 1'b0;
      rec_data_perr <= 1'b0;
    end else begin
      rec_valid <= 1'b0;
      if (take) begin
        if (skip != 2'd0) begin
          skip <= skip - 2'd1;
        end else begin
          case (st)
            S_REQ: begin
              rq <= rq_n;
              if (req_hit) begin
                cur_ap <= rq_n[6];
                cur_rd <= rq_n[5];
                cur_a <= {rq_n[3], rq_n[4]};
                cur_rp <= ^rq_n[6:2];
                st <= S_ACK;
                on_fall <= 1'b1;
                skip <= 2'd1;
                ak <= '0;
                cnt <= '0;
              end
            end
            S_ACK: begin
              ak <= ak_n;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(2)) begin
                cnt <= '0;
                if (data_ack) begin
                  st <= S_DATA;
                  on_fall <= cur_rd;
                  skip <= cur_rd ? 2'd0 : 2'd2;
                end else begin
                  rec_valid <= 1'b1;
                  rec_ap <= cur_ap;
                  rec_read <= cur_rd;
                  rec_addr <= {cur_a, 2'b00};
                  rec_ack <= ak_n;
                  rec_data <= '0;
                  rec_req_perr <= cur_rp;
                  rec_data_perr <= 1'b0;
                  st <= S_REQ;
                  rq <= '0;
                  on_fall <= 1'b0;
                  skip <= wf ? 2'd1 : 2'd0;
                end
              end
            end
            S_DATA: begin
              dsh <= {bit_i, dsh[DW-1:1]};
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW - 1)) begin
                cnt <= '0;
                st <= S_DPAR;
              end
            end
            default: begin
              rec_valid <= 1'b1;
              rec_ap <= cur_ap;
              rec_read <= cur_rd;
              rec_addr <= {cur_a, 2'b00};
              rec_ack <= ak;
              rec_data <= dsh;
              rec_req_perr <= cur_rp;
              rec_data_perr <= dp_bad;
              if (!cur_ap && !cur_rd && ak == ACK_OK && !dp_bad) begin
                if (cur_a == 2'b10) csel <= dsh[0];
                else if (cur_a == 2'b01 && !csel) orun <= dsh[0];
              end
              st <= S_REQ;
              rq <= '0;
              on_fall <= 1'b0;
              skip <= cur_rd ? 2'd1 : 2'd0;
            end
          endcase
        end
      end
    end
  end
endmodule

module swd_txn_monitor_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_valid,
  input logic          rec_ap,
  input logic          rec_read,
  input logic [3:0]    rec_addr,
  input logic [2:0]    rec_ack,
  input logic [DW-1:0] rec_data,
  input logic          rec_req_perr,
  input logic          rec_data_perr
);
  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> $stable({rec_ap, rec_read, rec_addr, rec_ack, rec_data, rec_req_perr, rec_data_perr}));

  assert_noreply_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ack == 3'b111) |-> (rec_data == '0 && !rec_data_perr));

  assert_dperr_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_data_perr) |-> (rec_ack == 3'b100 || rec_ack == 3'b010 || rec_ack == 3'b001));
endmodule

bind swd_txn_monitor swd_txn_monitor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ap(rec_ap),
  .rec_read(rec_read), .rec_addr(rec_addr), .rec_ack(rec_ack),
  .rec_data(rec_data), .rec_req_perr(rec_req_perr), .rec_data_perr(rec_data_perr)
);

// File: tb/tb_swd_txn_monitor.sv
module tb_swd_txn_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic dio = 1'b0;
  logic        rec_valid, rec_ap, rec_read, rec_req_perr, rec_data_perr;
  logic [3:0]  rec_addr;
  logic [2:0]  rec_ack;
  logic [31:0] rec_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic m_csel = 1'b0;
  logic m_orun = 1'b0;
  logic [42:0] exp_q[$];
  string tag_q[$];
  logic [42:0] last_exp = '0;

  always #2.5 clk = ~clk;

  swd_txn_monitor #(.DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .swclk_i(sck), .swdio_i(dio),
    .rec_valid(rec_valid), .rec_ap(rec_ap), .rec_read(rec_read),
    .rec_addr(rec_addr), .rec_ack(rec_ack), .rec_data(rec_data),
    .rec_req_perr(rec_req_perr), .rec_data_perr(rec_data_perr)
  );

  wire [42:0] got = {rec_ap, rec_read, rec_addr, rec_ack, rec_data, rec_req_perr, rec_data_perr};

  always @(negedge clk) begin
    if (rst_n && rec_valid && !done) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected record: actual %h expected none", got);
      end else begin
        logic [42:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s record: actual %h expected %h", t, got, e);
        end
      end
    end
  end

  task automatic swcyc(input logic b);
    @(negedge clk);
    dio = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic txn(input string tag, input logic ap, input logic rd,
                     input logic [3:0] addr, input logic [2:0] ack,
                     input logic [31:0] d, input logic badrp, input logic baddp,
                     input int idle);
    logic par;
    logic has;
    par = ap ^ rd ^ addr[2] ^ addr[3] ^ badrp;
    has = (ack == 3'b100) || ((ack == 3'b010 || ack == 3'b001) && m_orun);
    exp_q.push_back({ap, rd, addr, ack, has ? d : 32'h0, badrp, has & baddp});
    tag_q.push_back(tag);
    swcyc(1'b1); swcyc(ap); swcyc(rd); swcyc(addr[2]);
    swcyc(addr[3]); swcyc(par); swcyc(1'b0); swcyc(1'b1);
    swcyc(ack[2]); swcyc(ack[1]); swcyc(ack[0]);
    if (has) begin
      if (!rd) begin swcyc(1'b0); swcyc(1'b0); end
      for (int i = 0; i < 32; i++) swcyc(d[i]);
      swcyc((^d) ^ baddp);
      if (!ap && !rd && ack == 3'b100 && !baddp) begin
        if (addr == 4'h8) m_csel = d[0];
        else if (addr == 4'h4 && !m_csel) m_orun = d[0];
      end
    end
    for (int i = 0; i < idle; i++) swcyc(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (got !== '0 || rec_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state: actual %h/%b expected 0/0", got, rec_valid);
    end
    for (int i = 0; i < 3; i++) swcyc(1'b0);
    txn("R2/R5 DP read OK", 1'b0, 1'b1, 4'h0, 3'b100, 32'h1234_5678, 1'b0, 1'b0, 1);
    txn("R6/R7 AP write back-to-back", 1'b1, 1'b0, 4'hC, 3'b100, 32'hA5A5_0F0F, 1'b0, 1'b0, 0);
    txn("R3 request parity error", 1'b0, 1'b1, 4'h4, 3'b100, 32'h8000_0001, 1'b1, 1'b0, 2);
    txn("R5 data parity error", 1'b1, 1'b1, 4'h8, 3'b100, 32'hDEAD_BEEF, 1'b0, 1'b1, 1);
    txn("R8 WAIT without data", 1'b1, 1'b1, 4'h4, 3'b010, 32'h1111_2222, 1'b0, 1'b0, 1);
    txn("R8 FAULT without data", 1'b0, 1'b0, 4'hC, 3'b001, 32'h3333_4444, 1'b0, 1'b0, 1);
    txn("R8 no reply no skip", 1'b1, 1'b0, 4'h0, 3'b111, 32'h5555_6666, 1'b0, 1'b0, 0);
    txn("R4 protocol error ack", 1'b0, 1'b1, 4'h8, 3'b000, 32'h7777_8888, 1'b0, 1'b0, 0);
    txn("R10 set overrun detect", 1'b0, 1'b0, 4'h4, 3'b100, 32'h0000_0001, 1'b0, 1'b0, 0);
    txn("R9 WAIT read with data", 1'b1, 1'b1, 4'h0, 3'b010, 32'hCAFE_F00D, 1'b0, 1'b0, 1);
    txn("R9 FAULT write with data", 1'b1, 1'b0, 4'h4, 3'b001, 32'h0BAD_C0DE, 1'b0, 1'b0, 0);
    txn("R10 set select bit", 1'b0, 1'b0, 4'h8, 3'b100, 32'h0000_0001, 1'b0, 1'b0, 0);
    txn("R10 blocked clear", 1'b0, 1'b0, 4'h4, 3'b100, 32'h0000_0000, 1'b0, 1'b0, 0);
    txn("R10 overrun still on", 1'b1, 1'b1, 4'hC, 3'b010, 32'h0F0F_F0F0, 1'b0, 1'b0, 1);
    txn("R10 clear select bit", 1'b0, 1'b0, 4'h8, 3'b100, 32'h0000_0000, 1'b0, 1'b0, 0);
    txn("R10 clear overrun", 1'b0, 1'b0, 4'h4, 3'b100, 32'h0000_0000, 1'b0, 1'b0, 0);
    txn("R9 WAIT after clear", 1'b1, 1'b1, 4'h0, 3'b010, 32'h1357_9BDF, 1'b0, 1'b0, 1);
    txn("R7 read then one idle", 1'b0, 1'b1, 4'hC, 3'b100, 32'hFFFF_0000, 1'b0, 1'b0, 2);
    repeat (20) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing records: actual %0d pending expected 0", exp_q.size());
    end
    n_chk++;
    if (got !== last_exp || rec_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 fields hold: actual %h expected %h", got, last_exp);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule